// File: doc/BRIEF.md
# Frame Status Queue

This block works next to the receive data FIFO of a bit-oriented synchronous (SDLC/HDLC) receiver. Each time the deframer reports a closing flag, the block stores that frame's byte count and receive status as one entry in a small first-in first-out queue. The host or a DMA engine then reads the length and status of each frame in arrival order, even after several frames have been received back to back.

The block also runs the end-of-frame interrupt and lock sequencing. When the byte carrying the end-of-frame mark reaches the exit of the data FIFO, a small controller either raises a special-condition request or raises an ordinary data-available request. After the host reads status, the controller may hold the data FIFO locked until an error-reset command arrives. There is one enhanced combination: the queue is enabled and the special-condition-only mode is selected. In that combination end of frame raises the data-available request and never locks the data FIFO, so bytes of the next frame keep arriving. The host then needs only a reset-highest-under-service command.

Controller states: `ST_IDLE` (nothing pending), `ST_SPEC_PEND` (special-condition request raised), `ST_LOCKED` (data FIFO locked), `ST_AVAIL_PEND` (enhanced data-available request raised). Transitions:

- `ST_IDLE`→`ST_AVAIL_PEND` on the mark reaching the exit while enhanced.
- `ST_IDLE`→`ST_SPEC_PEND` on the mark reaching the exit in any other non-off mode.
- `ST_SPEC_PEND`→`ST_IDLE` on error reset, or on a status read in every-character or off mode.
- `ST_SPEC_PEND`→`ST_LOCKED` on a status read in first-character or special-only mode.
- `ST_LOCKED`→`ST_IDLE` on error reset.
- `ST_AVAIL_PEND`→`ST_IDLE` on reset-highest-under-service.

Top module: `frame_status_queue`

## Requirements
- R1: After reset, `fifo_avail`, `fifo_ovf`, `irq_special`, `irq_rx_avail` and `data_lock` are 0, and `head_count` and `head_status` are 0.
- R2: While `cfg_fifo_en` is 1, an `eof_valid` pulse stores the frame's count and status. The oldest stored entry appears on `head_count`/`head_status` in the cycle after it becomes oldest. `fifo_avail` is 1 exactly while one or more entries are held, and the head outputs read 0 when the queue is empty.
- R3: The queue holds 10 entries. An `eof_valid` that arrives with 10 entries held and no pop in the same cycle is discarded and sets `fifo_ovf`. `fifo_ovf` then stays 1 until `cfg_fifo_en` is 0 or reset.
- R4: A `host_stat_rd` pulse while an entry is held removes the head entry. The next entry appears in the following cycle.
- R5: While `cfg_fifo_en` is 0, no entry is stored, the queue is emptied and `fifo_ovf` is cleared.
- R6: Stored byte counts are 14 bits wide. An input count (16 bits) above 16383 is stored as 16383.
- R7: A push and a pop in the same cycle on a full queue both take effect: the head advances, the new entry is kept, and `fifo_ovf` is not set.
- R8: The `cfg_rx_mode` encoding is: 0 = no receive interrupt, 1 = first character or special condition, 2 = every character or special condition, 3 = special condition only. Outside the enhanced combination, `eof_at_exit` seen in `ST_IDLE` with a non-zero mode raises `irq_special` in the next cycle. At most one of `irq_special`, `irq_rx_avail`, `data_lock` is 1.
- R9: In modes 1 and 3 without the enhancement, a `host_stat_rd` while `irq_special` is 1 drops `irq_special` and raises `data_lock` in the next cycle. `data_lock` holds until `cmd_err_reset`. In mode 2 the same read returns to idle with no lock.
- R10: With `cfg_fifo_en`=1 and mode 3, `eof_at_exit` raises `irq_rx_avail` (never `irq_special`), no status read locks the data FIFO, and `cmd_reset_ius` clears `irq_rx_avail`.
- R11: `eof_at_exit` while a request is pending or the data FIFO is locked has no effect. `cmd_err_reset` cancels a pending special-condition request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eof_valid | input | 1 | End-of-frame detected (one-cycle pulse) |
| eof_count | input | 16 | Byte count of the frame just ended |
| eof_status | input | 8 | Receive status bits of that frame |
| eof_at_exit | input | 1 | End-of-frame marked byte reached the data FIFO exit |
| cfg_fifo_en | input | 1 | Status queue enable |
| cfg_rx_mode | input | 2 | Receive interrupt mode (see R8) |
| host_stat_rd | input | 1 | Host status read strobe; pops the head entry |
| cmd_err_reset | input | 1 | Error-reset command |
| cmd_reset_ius | input | 1 | Reset-highest-under-service command |
| head_count | output | 14 | Byte count of the oldest entry |
| head_status | output | 8 | Status of the oldest entry |
| fifo_avail | output | 1 | At least one entry is held |
| fifo_ovf | output | 1 | Sticky overflow flag |
| irq_special | output | 1 | Special-condition interrupt request |
| irq_rx_avail | output | 1 | Receive-data-available interrupt request |
| data_lock | output | 1 | Data FIFO lock |

## Verification
Two things can land on the same clock edge. A new end-of-frame push can meet a status read, and that read both pops the queue and services the controller. The case that matters is a full queue, where the push must survive without raising overflow because the pop frees a slot. A second case is a pending special condition, where the same read has to lock the data FIFO and also advance the head. The directed phase builds both cases on purpose: it fills the queue to ten entries and then strobes push and read together, and it reads status while a special condition is pending. A random phase then creates many more overlaps, including enable and mode changes. A behavioural queue-and-state model judges every cycle.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'd0,
        MODE_FIRST   = 2'd1,
        MODE_ALL     = 2'd2,
        MODE_SPECIAL = 2'd3
    } rx_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SPEC_PEND,
        ST_LOCKED,
        ST_AVAIL_PEND
    } ctl_state_e;

endpackage

// File: rtl/fsq_store.sv
module fsq_store #(
    parameter int DEPTH    = 10,
    parameter int CNT_W    = 14,
    parameter int IN_CNT_W = 16,
    parameter int STAT_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                push_req,
    input  logic [IN_CNT_W-1:0] push_count,
    input  logic [STAT_W-1:0]   push_status,
    input  logic                pop_req,
    output logic [CNT_W-1:0]    head_count,
    output logic [STAT_W-1:0]   head_status,
    output logic                not_empty,
    output logic                overflow
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0]    CNT_MAX  = '1;
    localparam logic [IN_CNT_W-1:0] CNT_MAXW = {{(IN_CNT_W-CNT_W){1'b0}}, CNT_MAX};
    localparam logic [PTR_W-1:0]    PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [OCC_W-1:0]    OCC_FULL = OCC_W'(DEPTH);

    logic [CNT_W-1:0]  mem_cnt [DEPTH];
    logic [STAT_W-1:0] mem_st  [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [OCC_W-1:0]  occ;

    logic             pop_ok, push_ok, push_drop;
    logic [CNT_W-1:0] sat_count;

    assign pop_ok    = pop_req && (occ != '0);
    assign push_ok   = enable && push_req && ((occ != OCC_FULL) || pop_ok);
    assign push_drop = enable && push_req && (occ == OCC_FULL) && !pop_ok;
    assign sat_count = (push_count > CNT_MAXW) ? CNT_MAX : push_count[CNT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            occ      <= '0;
            overflow <= 1'b0;
        end else if (!enable) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            occ      <= '0;
            overflow <= 1'b0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            if (push_ok && !pop_ok)
                occ <= occ + 1'b1;
            else if (pop_ok && !push_ok)
                occ <= occ - 1'b1;
            if (push_drop)
                overflow <= 1'b1;
        end
    end

    // Entry storage: one slot per frame, written at the write pointer.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_cnt[gi] <= '0;
                mem_st[gi]  <= '0;
            end else if (push_ok && (wr_ptr == PTR_W'(gi))) begin
                mem_cnt[gi] <= sat_count;
                mem_st[gi]  <= push_status;
            end
        end
    end

    assign not_empty   = (occ != '0);
    assign head_count  = not_empty ? mem_cnt[rd_ptr] : '0;
    assign head_status = not_empty ? mem_st[rd_ptr]  : '0;

endmodule

// File: rtl/fsq_ctrl.sv
module fsq_ctrl
    import fsq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     fifo_en,
    input  rx_mode_e mode,
    input  logic     mark_at_exit,
    input  logic     stat_rd,
    input  logic     err_reset,
    input  logic     reset_ius,
    output logic     irq_special,
    output logic     irq_rx_avail,
    output logic     data_lock
);

    ctl_state_e state, state_nxt;
    logic       enhanced, lock_mode;

    assign enhanced  = fifo_en && (mode == MODE_SPECIAL);
    assign lock_mode = (mode == MODE_FIRST) || (mode == MODE_SPECIAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (mark_at_exit) begin
                    if (enhanced)
                        state_nxt = ST_AVAIL_PEND;
                    else if (mode != MODE_OFF)
                        state_nxt = ST_SPEC_PEND;
                end
            end
            ST_SPEC_PEND: begin
                if (err_reset)
                    state_nxt = ST_IDLE;
                else if (stat_rd)
                    state_nxt = lock_mode ? ST_LOCKED : ST_IDLE;
            end
            ST_LOCKED: begin
                if (err_reset)
                    state_nxt = ST_IDLE;
            end
            ST_AVAIL_PEND: begin
                if (reset_ius)
                    state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        irq_special  = 1'b0;
        irq_rx_avail = 1'b0;
        data_lock    = 1'b0;
        unique case (state)
            ST_IDLE:       ;
            ST_SPEC_PEND:  irq_special  = 1'b1;
            ST_LOCKED:     data_lock    = 1'b1;
            ST_AVAIL_PEND: irq_rx_avail = 1'b1;
            default:       ;
        endcase
    end

endmodule

// File: rtl/frame_status_queue.sv
module frame_status_queue
    import fsq_pkg::*;
#(
    parameter int DEPTH    = 10,
    parameter int CNT_W    = 14,
    parameter int IN_CNT_W = 16,
    parameter int STAT_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                eof_valid,
    input  logic [IN_CNT_W-1:0] eof_count,
    input  logic [STAT_W-1:0]   eof_status,
    input  logic                eof_at_exit,
    input  logic                cfg_fifo_en,
    input  logic [1:0]          cfg_rx_mode,
    input  logic                host_stat_rd,
    input  logic                cmd_err_reset,
    input  logic                cmd_reset_ius,
    output logic [CNT_W-1:0]    head_count,
    output logic [STAT_W-1:0]   head_status,
    output logic                fifo_avail,
    output logic                fifo_ovf,
    output logic                irq_special,
    output logic                irq_rx_avail,
    output logic                data_lock
);

    rx_mode_e mode;
    assign mode = rx_mode_e'(cfg_rx_mode);

    fsq_store #(
        .DEPTH    (DEPTH),
        .CNT_W    (CNT_W),
        .IN_CNT_W (IN_CNT_W),
        .STAT_W   (STAT_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (cfg_fifo_en),
        .push_req    (eof_valid),
        .push_count  (eof_count),
        .push_status (eof_status),
        .pop_req     (host_stat_rd),
        .head_count  (head_count),
        .head_status (head_status),
        .not_empty   (fifo_avail),
        .overflow    (fifo_ovf)
    );

    fsq_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_en      (cfg_fifo_en),
        .mode         (mode),
        .mark_at_exit (eof_at_exit),
        .stat_rd      (host_stat_rd),
        .err_reset    (cmd_err_reset),
        .reset_ius    (cmd_reset_ius),
        .irq_special  (irq_special),
        .irq_rx_avail (irq_rx_avail),
        .data_lock    (data_lock)
    );

endmodule

// File: rtl/fsq_checker.sv
module fsq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       eof_valid,
    input logic       eof_at_exit,
    input logic       cfg_fifo_en,
    input logic [1:0] cfg_rx_mode,
    input logic       host_stat_rd,
    input logic       cmd_err_reset,
    input logic       cmd_reset_ius,
    input logic       fifo_avail,
    input logic       fifo_ovf,
    input logic       irq_special,
    input logic       irq_rx_avail,
    input logic       data_lock
);

    p_push_avail_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fifo_en && eof_valid) |=> fifo_avail);

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_ovf && cfg_fifo_en) |=> fifo_ovf);

    p_disable_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_fifo_en |=> (!fifo_avail && !fifo_ovf));

    p_one_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_special, irq_rx_avail, data_lock}));

    p_special_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_special) |-> ($past(eof_at_exit) &&
                                !$past(cfg_fifo_en && (cfg_rx_mode == 2'd3))));

    p_lock_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_lock) |-> $past(host_stat_rd));

    p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_lock && !cmd_err_reset) |=> data_lock);

    p_avail_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_rx_avail) |-> $past(eof_at_exit && cfg_fifo_en && (cfg_rx_mode == 2'd3)));

    p_avail_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rx_avail && !cmd_reset_ius) |=> irq_rx_avail);

endmodule

bind frame_status_queue fsq_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .eof_valid     (eof_valid),
    .eof_at_exit   (eof_at_exit),
    .cfg_fifo_en   (cfg_fifo_en),
    .cfg_rx_mode   (cfg_rx_mode),
    .host_stat_rd  (host_stat_rd),
    .cmd_err_reset (cmd_err_reset),
    .cmd_reset_ius (cmd_reset_ius),
    .fifo_avail    (fifo_avail),
    .fifo_ovf      (fifo_ovf),
    .irq_special   (irq_special),
    .irq_rx_avail  (irq_rx_avail),
    .data_lock     (data_lock)
);

// File: tb/frame_status_queue_bench.sv
`timescale 1ns/1ps
module frame_status_queue_bench;

    localparam int DEPTH    = 10;
    localparam int CNT_W    = 14;
    localparam int IN_CNT_W = 16;
    localparam int STAT_W   = 8;
    localparam int CMAX     = 16383;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                eof_valid = 1'b0;
    logic [IN_CNT_W-1:0] eof_count = '0;
    logic [STAT_W-1:0]   eof_status = '0;
    logic                eof_at_exit = 1'b0;
    logic                cfg_fifo_en = 1'b0;
    logic [1:0]          cfg_rx_mode = 2'd0;
    logic                host_stat_rd = 1'b0;
    logic                cmd_err_reset = 1'b0;
    logic                cmd_reset_ius = 1'b0;
    logic [CNT_W-1:0]    head_count;
    logic [STAT_W-1:0]   head_status;
    logic                fifo_avail, fifo_ovf, irq_special, irq_rx_avail, data_lock;

    always #4 clk = ~clk;

    frame_status_queue #(
        .DEPTH(DEPTH), .CNT_W(CNT_W), .IN_CNT_W(IN_CNT_W), .STAT_W(STAT_W)
    ) u_frame_status_queue (
        .clk(clk), .rst_n(rst_n), .eof_valid(eof_valid), .eof_count(eof_count),
        .eof_status(eof_status), .eof_at_exit(eof_at_exit), .cfg_fifo_en(cfg_fifo_en),
        .cfg_rx_mode(cfg_rx_mode), .host_stat_rd(host_stat_rd),
        .cmd_err_reset(cmd_err_reset), .cmd_reset_ius(cmd_reset_ius),
        .head_count(head_count), .head_status(head_status), .fifo_avail(fifo_avail),
        .fifo_ovf(fifo_ovf), .irq_special(irq_special), .irq_rx_avail(irq_rx_avail),
        .data_lock(data_lock)
    );

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: queue of entries plus a state number
    // 0 idle, 1 special pending, 2 locked, 3 data-available pending.
    int q_cnt[$];
    int q_st[$];
    bit m_ovf;
    int m_st;

    always @(posedge clk) begin
        if (!rst_n) begin
            q_cnt.delete();
            q_st.delete();
            m_ovf = 1'b0;
            m_st  = 0;
        end else begin
            int nxt;
            nxt = m_st;
            if (!cfg_fifo_en) begin
                q_cnt.delete();
                q_st.delete();
                m_ovf = 1'b0;
            end else begin
                if (host_stat_rd && q_cnt.size() > 0) begin
                    void'(q_cnt.pop_front());
                    void'(q_st.pop_front());
                end
                if (eof_valid) begin
                    if (q_cnt.size() < DEPTH) begin
                        q_cnt.push_back((int'(eof_count) > CMAX) ? CMAX : int'(eof_count));
                        q_st.push_back(int'(eof_status));
                    end else begin
                        m_ovf = 1'b1;
                    end
                end
            end
            case (m_st)
                0: if (eof_at_exit) begin
                       if (cfg_fifo_en && cfg_rx_mode == 2'd3) nxt = 3;
                       else if (cfg_rx_mode != 2'd0)          nxt = 1;
                   end
                1: if (cmd_err_reset) nxt = 0;
                   else if (host_stat_rd)
                       nxt = (cfg_rx_mode == 2'd1 || cfg_rx_mode == 2'd3) ? 2 : 0;
                2: if (cmd_err_reset) nxt = 0;
                default: if (cmd_reset_ius) nxt = 0;
            endcase
            m_st = nxt;
        end
    end

    // Cycle-by-cycle comparison against the reference.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 fifo_avail", int'(fifo_avail), int'(q_cnt.size() > 0));
            chk("R2/R6 head_count", int'(head_count), (q_cnt.size() > 0) ? q_cnt[0] : 0);
            chk("R2 head_status", int'(head_status), (q_st.size() > 0) ? q_st[0] : 0);
            chk("R3 fifo_ovf", int'(fifo_ovf), int'(m_ovf));
            chk("R8 irq_special", int'(irq_special), int'(m_st == 1));
            chk("R9 data_lock", int'(data_lock), int'(m_st == 2));
            chk("R10 irq_rx_avail", int'(irq_rx_avail), int'(m_st == 3));
        end
    end

    task automatic tick();
        @(negedge clk);
        eof_valid     = 1'b0;
        eof_at_exit   = 1'b0;
        host_stat_rd  = 1'b0;
        cmd_err_reset = 1'b0;
        cmd_reset_ius = 1'b0;
    endtask

    task automatic push(int cnt, int st);
        eof_valid  = 1'b1;
        eof_count  = IN_CNT_W'(cnt);
        eof_status = STAT_W'(st);
        tick();
    endtask

    task automatic flush();
        cfg_fifo_en = 1'b0;
        tick();
        cfg_fifo_en = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 fifo_avail", int'(fifo_avail), 0);
        chk("R1 fifo_ovf", int'(fifo_ovf), 0);
        chk("R1 requests", int'({irq_special, irq_rx_avail, data_lock}), 0);
        chk("R1 head_count", int'(head_count), 0);

        // R2 storing and order
        cfg_fifo_en = 1'b1;
        push(5, 8'hA1);
        push(6, 8'hA2);
        push(7, 8'hA3);
        chk("R2 head_count oldest", int'(head_count), 5);
        chk("R2 head_status oldest", int'(head_status), 8'hA1);
        // R4 pop
        host_stat_rd = 1'b1;
        tick();
        chk("R4 head after pop", int'(head_count), 6);

        // R6 saturation
        flush();
        push(20000, 1);
        chk("R6 saturated count", int'(head_count), CMAX);
        push(CMAX, 2);
        host_stat_rd = 1'b1;
        tick();
        chk("R6 exact max kept", int'(head_count), CMAX);

        // R3 overflow on the 11th frame, sticky through a pop
        flush();
        for (int i = 0; i < DEPTH; i++) push(100 + i, i);
        chk("R3 no overflow at ten", int'(fifo_ovf), 0);
        push(999, 9);
        chk("R3 overflow set", int'(fifo_ovf), 1);
        host_stat_rd = 1'b1;
        tick();
        chk("R3 overflow sticky", int'(fifo_ovf), 1);

        // R7 push and pop together on a full queue
        flush();
        for (int i = 0; i < DEPTH; i++) push(200 + i, i);
        host_stat_rd = 1'b1;
        push(500, 55);
        chk("R7 no overflow", int'(fifo_ovf), 0);
        chk("R7 head advanced", int'(head_count), 201);
        for (int i = 0; i < DEPTH - 1; i++) begin
            host_stat_rd = 1'b1;
            tick();
        end
        chk("R7 new entry kept", int'(head_count), 500);

        // R5 disabled queue ignores end of frame and clears
        cfg_fifo_en = 1'b0;
        push(42, 3);
        chk("R5 nothing stored", int'(fifo_avail), 0);
        chk("R5 overflow cleared", int'(fifo_ovf), 0);

        // R8 / R9 lock sequence in first-character mode
        cfg_rx_mode = 2'd1;
        eof_at_exit = 1'b1;
        tick();
        chk("R8 special raised", int'(irq_special), 1);
        eof_at_exit = 1'b1;              // R11 ignored while pending
        tick();
        chk("R11 still special", int'(irq_special), 1);
        host_stat_rd = 1'b1;
        tick();
        chk("R9 locked", int'(data_lock), 1);
        chk("R9 special dropped", int'(irq_special), 0);
        eof_at_exit = 1'b1;
        tick();
        tick();
        chk("R9 lock holds", int'(data_lock), 1);
        cmd_err_reset = 1'b1;
        tick();
        chk("R9 unlocked", int'(data_lock), 0);

        // R9 every-character mode: no lock
        cfg_rx_mode = 2'd2;
        eof_at_exit = 1'b1;
        tick();
        host_stat_rd = 1'b1;
        tick();
        chk("R9 mode2 no lock", int'(data_lock), 0);
        chk("R9 mode2 idle", int'(irq_special), 0);

        // R11 error reset cancels pending special; mode 0 raises nothing
        cfg_rx_mode = 2'd3;
        eof_at_exit = 1'b1;
        tick();
        chk("R8 special without queue", int'(irq_special), 1);
        cmd_err_reset = 1'b1;
        tick();
        chk("R11 cancel", int'(irq_special), 0);
        cfg_rx_mode = 2'd0;
        eof_at_exit = 1'b1;
        tick();
        chk("R8 mode0 silent", int'({irq_special, irq_rx_avail, data_lock}), 0);

        // R10 enhanced combination
        cfg_fifo_en = 1'b1;
        cfg_rx_mode = 2'd3;
        push(77, 4);
        eof_at_exit = 1'b1;
        tick();
        chk("R10 data-available", int'(irq_rx_avail), 1);
        chk("R10 not special", int'(irq_special), 0);
        host_stat_rd = 1'b1;
        eof_valid    = 1'b1;
        eof_count    = 16'd12;
        tick();
        chk("R10 no lock", int'(data_lock), 0);
        chk("R10 next frame stored", int'(head_count), 12);
        cmd_reset_ius = 1'b1;
        tick();
        chk("R10 cleared", int'(irq_rx_avail), 0);

        // Random overlap phase
        for (int c = 0; c < 4000; c++) begin
            eof_valid     = ($urandom_range(0, 2) == 0);
            eof_count     = ($urandom_range(0, 7) == 0) ? 16'($urandom_range(16000, 65535))
                                                        : 16'($urandom_range(0, 300));
            eof_status    = 8'($urandom_range(0, 255));
            eof_at_exit   = ($urandom_range(0, 4) == 0);
            host_stat_rd  = ($urandom_range(0, 3) == 0);
            cmd_err_reset = ($urandom_range(0, 9) == 0);
            cmd_reset_ius = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 99) == 0) cfg_fifo_en = ~cfg_fifo_en;
            if ($urandom_range(0, 49) == 0) cfg_rx_mode = 2'($urandom_range(0, 3));
            tick();
        end

        tick();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule